// File: doc/BRIEF.md
# Quadrature and Pulse/Direction Count Decoder

This block turns two encoder lines, A and B, into a single-cycle count strobe and an up/down level for a downstream position counter. A two-bit mode input picks one of four decoding functions: pulse/direction, where A is a count clock and B gives the direction, or quadrature decoding at one, two or four counts per encoder cycle. Both lines first cross into the clock domain through a synchroniser chain. A phase tracker then records the last sampled (A,B) pair. The decode stage registers a count strobe, the direction of the most recent count, and a sticky noise flag.

The phase tracker is a state machine with five states. ST_WAIT is entered at reset and suppresses any event on the first sample. ST_P00, ST_P10, ST_P11 and ST_P01 name the last seen (A,B) phase. From every state the next state is the phase of the current sample. Each cycle the tracker classifies the step from its state to the current sample as TR_NONE, TR_A (only A changed), TR_B (only B changed) or TR_BOTH (both changed in one sample). The tracker keeps following the lines while counting is disabled, so enabling the inputs never produces a spurious count.

In a quadrature mode, the forward (up) direction is the phase order (A,B) = 00, 10, 11, 01, 00. When both lines move in the same sample in a quadrature mode, no count is made and the noise flag is set. The flag stays set until the clear input is applied.

Top module: `quad_count_decoder`

## Requirements
- R1: After reset, count_pulse is 0, count_up is 1 and noise_err is 0.
- R2: With mode_sel = 2'b00 (pulse/direction), a rising edge of A gives one count; a falling edge of A and any change of B give none. count_up takes the level of B in the sample where A rose (1 = up).
- R3: With mode_sel = 2'b01 (x1), a change of A gives a count only while B is 0. That is a rising A edge when moving up and a falling A edge when moving down, so one full encoder cycle gives one count in either direction.
- R4: With mode_sel = 2'b10 (x2), every single-line change of A gives a count and changes of B give none: two counts per encoder cycle.
- R5: With mode_sel = 2'b11 (x4), every single-line change of A or of B gives a count: four counts per encoder cycle.
- R6: In the quadrature modes, a count caused by a step along 00, 10, 11, 01, 00 sets count_up to 1, and a count caused by a step the other way sets it to 0. count_up changes only in a cycle where count_pulse is 1.
- R7: While in_enable is 0, line activity produces neither a count nor a noise error. Setting in_enable to 1 with the lines at rest produces no count.
- R8: In a quadrature mode with in_enable = 1, a sample in which A and B both changed produces no count and sets noise_err. noise_err then stays 1 while counting goes on.
- R9: err_clear = 1 for one cycle clears noise_err. If a new error occurs in the same cycle as the clear, the error wins and noise_err stays 1.
- R10: A line change that is present at clock edge k appears on count_pulse after edge k+2 and lasts one cycle (SYNC_STAGES = 2).
- R11: In pulse/direction mode, A and B changing in the same sample is legal: it counts if A rose and never sets noise_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Decode function: 00 pulse/dir, 01 x1, 10 x2, 11 x4 |
| in_enable | input | 1 | 1 lets line activity count; 0 ignores it |
| err_clear | input | 1 | One-cycle strobe that clears noise_err |
| line_a | input | 1 | Encoder line A (asynchronous) |
| line_b | input | 1 | Encoder line B (asynchronous) |
| count_pulse | output | 1 | One-cycle count strobe |
| count_up | output | 1 | Direction of the last count, 1 = up |
| noise_err | output | 1 | Sticky error flag for an illegal quadrature step |

## Verification
A phase tracker holding the wrong phase shows up at the ports within three cycles of the next line change. It appears as a missing or extra strobe, a strobe with the wrong count_up, or a false noise error, because every count decision compares the tracked phase with the new sample. A wrong mode decode changes the number of strobes per encoder cycle, and the bench checks that against the 1/2/4 ratio. A flag that fails to stick or fails to clear is visible on noise_err one cycle after the cycle that should have set or cleared it. The reference model predicts all three outputs every clock, so the first wrong cycle is reported.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [1:0] {
        MODE_PULSE_DIR = 2'b00,
        MODE_QUAD_X1   = 2'b01,
        MODE_QUAD_X2   = 2'b10,
        MODE_QUAD_X4   = 2'b11
    } count_mode_e;

    typedef enum logic [2:0] {
        ST_WAIT = 3'd0,
        ST_P00  = 3'd1,
        ST_P10  = 3'd2,
        ST_P11  = 3'd3,
        ST_P01  = 3'd4
    } phase_state_e;

    typedef enum logic [1:0] {
        TR_NONE = 2'd0,
        TR_A    = 2'd1,
        TR_B    = 2'd2,
        TR_BOTH = 2'd3
    } trans_e;

    // Map a sampled (A,B) pair onto its tracking state.
    function automatic phase_state_e phase_of(input logic a, input logic b);
        phase_state_e p;
        case ({a, b})
            2'b00:   p = ST_P00;
            2'b10:   p = ST_P10;
            2'b11:   p = ST_P11;
            default: p = ST_P01;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = pipe[LAST];

endmodule

// File: rtl/qdec_phase_fsm.sv
module qdec_phase_fsm
    import qdec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cur_a,
    input  logic   cur_b,
    output trans_e trans
);

    phase_state_e state, state_nxt;
    logic         prev_a, prev_b, tracked;

    // State register: always follows the newest sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = phase_of(cur_a, cur_b);
    end

    // Output process: classify the step from the held phase to the sample.
    always_comb begin
        prev_a  = 1'b0;
        prev_b  = 1'b0;
        tracked = 1'b1;
        unique case (state)
            ST_WAIT: tracked = 1'b0;
            ST_P00:  begin prev_a = 1'b0; prev_b = 1'b0; end
            ST_P10:  begin prev_a = 1'b1; prev_b = 1'b0; end
            ST_P11:  begin prev_a = 1'b1; prev_b = 1'b1; end
            ST_P01:  begin prev_a = 1'b0; prev_b = 1'b1; end
            default: tracked = 1'b0;
        endcase

        if (!tracked) begin
            trans = TR_NONE;
        end else begin
            case ({cur_a ^ prev_a, cur_b ^ prev_b})
                2'b10:   trans = TR_A;
                2'b01:   trans = TR_B;
                2'b11:   trans = TR_BOTH;
                default: trans = TR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/qdec_event.sv
module qdec_event
    import qdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  count_mode_e mode,
    input  logic        enable,
    input  logic        err_clear,
    input  logic        cur_a,
    input  logic        cur_b,
    input  trans_e      trans,
    output logic        count_pulse,
    output logic        count_up,
    output logic        noise_err
);

    logic hit, dir, bad;
    logic dir_from_a, dir_from_b;

    // Forward order is 00,10,11,01: an A step is forward when A now differs
    // from B, a B step is forward when B now equals A.
    assign dir_from_a = cur_a ^ cur_b;
    assign dir_from_b = ~(cur_a ^ cur_b);

    always_comb begin
        hit = 1'b0;
        dir = count_up;
        bad = 1'b0;
        if (enable) begin
            unique case (mode)
                MODE_PULSE_DIR: begin
                    if ((trans == TR_A || trans == TR_BOTH) && cur_a) begin
                        hit = 1'b1;
                        dir = cur_b;
                    end
                end
                MODE_QUAD_X1: begin
                    if (trans == TR_A && !cur_b) begin
                        hit = 1'b1;
                        dir = dir_from_a;
                    end
                    bad = (trans == TR_BOTH);
                end
                MODE_QUAD_X2: begin
                    if (trans == TR_A) begin
                        hit = 1'b1;
                        dir = dir_from_a;
                    end
                    bad = (trans == TR_BOTH);
                end
                MODE_QUAD_X4: begin
                    if (trans == TR_A) begin
                        hit = 1'b1;
                        dir = dir_from_a;
                    end else if (trans == TR_B) begin
                        hit = 1'b1;
                        dir = dir_from_b;
                    end
                    bad = (trans == TR_BOTH);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_pulse <= 1'b0;
            count_up    <= 1'b1;
            noise_err   <= 1'b0;
        end else begin
            count_pulse <= hit;
            if (hit) count_up <= dir;
            noise_err <= bad | (noise_err & ~err_clear);
        end
    end

endmodule

// File: rtl/quad_count_decoder.sv
module quad_count_decoder
    import qdec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       in_enable,
    input  logic       err_clear,
    input  logic       line_a,
    input  logic       line_b,
    output logic       count_pulse,
    output logic       count_up,
    output logic       noise_err
);

    localparam int LINES = 2;

    logic [LINES-1:0] synced;
    trans_e           trans;

    qdec_sync #(
        .WIDTH (LINES),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({line_a, line_b}),
        .dout (synced)
    );

    qdec_phase_fsm u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .cur_a(synced[1]),
        .cur_b(synced[0]),
        .trans(trans)
    );

    qdec_event u_event (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (count_mode_e'(mode_sel)),
        .enable     (in_enable),
        .err_clear  (err_clear),
        .cur_a      (synced[1]),
        .cur_b      (synced[0]),
        .trans      (trans),
        .count_pulse(count_pulse),
        .count_up   (count_up),
        .noise_err  (noise_err)
    );

endmodule

// File: rtl/qdec_checker.sv
module qdec_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       in_enable,
    input logic       err_clear,
    input logic       count_pulse,
    input logic       count_up,
    input logic       noise_err
);

    // R7: a disabled cycle yields no count
    a_r7_disabled_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_enable) |-> !count_pulse);

    // R7: a disabled cycle cannot raise the error flag
    a_r7_disabled_no_error: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_enable) && !$past(noise_err)) |-> !noise_err);

    // R8: the flag holds until cleared
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_err && !err_clear) |=> noise_err);

    // R8: the step that raises the flag gives no count
    a_r8_err_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(noise_err) |-> !count_pulse);

    // R9: the flag only drops after a clear
    a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(noise_err) |-> $past(err_clear));

    // R11: pulse/direction mode never raises the flag
    a_r11_pd_no_error: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_sel) == 2'b00 && !$past(noise_err)) |-> !noise_err);

    // R6: direction moves only together with a count
    a_r6_dir_with_count: assert property (@(posedge clk) disable iff (!rst_n)
        !count_pulse |-> $stable(count_up));

endmodule

bind quad_count_decoder qdec_checker u_qdec_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .in_enable  (in_enable),
    .err_clear  (err_clear),
    .count_pulse(count_pulse),
    .count_up   (count_up),
    .noise_err  (noise_err)
);

// File: tb/tb_quad_count_decoder.sv
`timescale 1ns/1ps
module tb_quad_count_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       in_enable = 1'b0;
    logic       err_clear = 1'b0;
    logic       line_a = 1'b0;
    logic       line_b = 1'b0;
    wire        count_pulse, count_up, noise_err;

    always #4 clk = ~clk;

    quad_count_decoder dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_enable(in_enable),
        .err_clear(err_clear), .line_a(line_a), .line_b(line_b),
        .count_pulse(count_pulse), .count_up(count_up), .noise_err(noise_err)
    );

    int    checks = 0;
    int    fails = 0;
    int    obs_pulses = 0;
    int    ph = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    bit exp_pulse = 1'b0;
    bit exp_up    = 1'b1;
    bit exp_err   = 1'b0;
    bit hist_a[$] = '{1'b0, 1'b0, 1'b0};
    bit hist_b[$] = '{1'b0, 1'b0, 1'b0};

    function automatic int gidx(bit a, bit b);
        if (a) return b ? 2 : 1;
        return b ? 3 : 0;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: outputs after edge n follow the step in(n-3) -> in(n-2).
    always @(posedge clk) begin
        if (rst_n) begin
            bit oa, ob, na, nb, cnt, up, err;
            int step;
            hist_a.push_back(line_a);
            hist_b.push_back(line_b);
            if (hist_a.size() > 4) begin
                void'(hist_a.pop_front());
                void'(hist_b.pop_front());
            end
            oa = hist_a[0]; ob = hist_b[0];
            na = hist_a[1]; nb = hist_b[1];
            cnt = 1'b0; up = exp_up; err = 1'b0;
            if (in_enable) begin
                if (mode_sel == 2'b00) begin
                    if (!oa && na) begin cnt = 1'b1; up = nb; end
                end else if ((oa != na) && (ob != nb)) begin
                    err = 1'b1;
                end else if ((oa != na) || (ob != nb)) begin
                    step = (gidx(na, nb) - gidx(oa, ob) + 4) % 4;
                    up = (step == 1);
                    if (oa != na) begin
                        if (mode_sel == 2'b01) cnt = (up && na) || (!up && !na);
                        else                   cnt = 1'b1;
                    end else begin
                        cnt = (mode_sel == 2'b11);
                    end
                end
            end
            exp_pulse = cnt;
            if (cnt) exp_up = up;
            exp_err = err ? 1'b1 : (err_clear ? 1'b0 : exp_err);
        end
    end

    // Compare against the model on every clock, away from the edge.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (count_pulse) obs_pulses++;
            chk(count_pulse == exp_pulse, cur_req, "model count_pulse", count_pulse, exp_pulse);
            chk(count_up == exp_up, cur_req, "model count_up", count_up, exp_up);
            chk(noise_err == exp_err, cur_req, "model noise_err", noise_err, exp_err);
        end
    end

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ab(bit a, bit b);
        @(negedge clk);
        line_a = a;
        line_b = b;
        @(negedge clk);
    endtask

    task automatic move(int dir, int n);
        for (int i = 0; i < n; i++) begin
            ph = (ph + dir + 4) % 4;
            set_ab(ph == 1 || ph == 2, ph == 2 || ph == 3);
        end
    endtask

    task automatic window();
        @(negedge clk);
        obs_pulses = 0;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #2;
    endtask

    initial begin
        hold(3);
        rst_n = 1'b1;
        hold(2);
        chk(count_pulse == 1'b0, "R1", "reset count_pulse", count_pulse, 0);
        chk(count_up == 1'b1, "R1", "reset count_up", count_up, 1);
        chk(noise_err == 1'b0, "R1", "reset noise_err", noise_err, 0);

        // x4: two forward cycles, then one reverse cycle
        cur_req = "R5";
        @(negedge clk); mode_sel = 2'b11; in_enable = 1'b1;
        hold(2);
        window(); move(1, 8); hold(4);
        chk(obs_pulses == 8, "R5", "x4 forward counts", obs_pulses, 8);
        chk(count_up == 1'b1, "R6", "x4 forward dir", count_up, 1);
        cur_req = "R6";
        window(); move(-1, 4); hold(4);
        chk(obs_pulses == 4, "R5", "x4 reverse counts", obs_pulses, 4);
        chk(count_up == 1'b0, "R6", "x4 reverse dir", count_up, 0);

        // x2
        cur_req = "R4";
        @(negedge clk); mode_sel = 2'b10;
        window(); move(1, 4); hold(4);
        chk(obs_pulses == 2, "R4", "x2 counts per cycle", obs_pulses, 2);
        chk(count_up == 1'b1, "R4", "x2 forward dir", count_up, 1);

        // x1 both directions
        cur_req = "R3";
        @(negedge clk); mode_sel = 2'b01;
        window(); move(1, 4); hold(4);
        chk(obs_pulses == 1, "R3", "x1 forward counts", obs_pulses, 1);
        chk(count_up == 1'b1, "R3", "x1 forward dir", count_up, 1);
        window(); move(-1, 4); hold(4);
        chk(obs_pulses == 1, "R3", "x1 reverse counts", obs_pulses, 1);
        chk(count_up == 1'b0, "R3", "x1 reverse dir", count_up, 0);

        // latency: A rises before edge k, strobe after edge k+2 only
        cur_req = "R10";
        @(negedge clk); mode_sel = 2'b11;
        hold(4);
        @(negedge clk); line_a = 1'b1; ph = 1;
        after_edge();
        chk(count_pulse == 1'b0, "R10", "strobe after edge k", count_pulse, 0);
        after_edge();
        chk(count_pulse == 1'b0, "R10", "strobe after edge k+1", count_pulse, 0);
        after_edge();
        chk(count_pulse == 1'b1, "R10", "strobe after edge k+2", count_pulse, 1);
        after_edge();
        chk(count_pulse == 1'b0, "R10", "strobe after edge k+3", count_pulse, 0);

        // pulse/direction
        cur_req = "R2";
        @(negedge clk); mode_sel = 2'b00;
        set_ab(1, 1); hold(4);
        window();
        for (int i = 0; i < 3; i++) begin set_ab(0, 1); set_ab(1, 1); end
        hold(4);
        chk(obs_pulses == 3, "R2", "pd rising A counts up", obs_pulses, 3);
        chk(count_up == 1'b1, "R2", "pd dir with B high", count_up, 1);
        set_ab(1, 0); hold(4);
        window();
        for (int i = 0; i < 2; i++) begin set_ab(0, 0); set_ab(1, 0); end
        hold(4);
        chk(obs_pulses == 2, "R2", "pd rising A counts down", obs_pulses, 2);
        chk(count_up == 1'b0, "R2", "pd dir with B low", count_up, 0);

        // simultaneous change in pulse/direction mode
        cur_req = "R11";
        set_ab(0, 0); hold(4);
        window(); set_ab(1, 1); hold(4);
        chk(obs_pulses == 1, "R11", "pd both-change counts", obs_pulses, 1);
        chk(count_up == 1'b1, "R11", "pd both-change dir", count_up, 1);
        chk(noise_err == 1'b0, "R11", "pd both-change no error", noise_err, 0);

        // disabled inputs are ignored, and enabling injects nothing
        cur_req = "R7";
        @(negedge clk); in_enable = 1'b0; mode_sel = 2'b11;
        hold(2);
        window(); set_ab(0, 0); ph = 0; move(1, 4); hold(4);
        chk(obs_pulses == 0, "R7", "disabled counts", obs_pulses, 0);
        chk(noise_err == 1'b0, "R7", "disabled error", noise_err, 0);
        @(negedge clk); in_enable = 1'b1;
        window(); hold(6);
        chk(obs_pulses == 0, "R7", "counts on enable", obs_pulses, 0);

        // illegal quadrature step
        cur_req = "R8";
        window(); set_ab(1, 1); ph = 2; hold(4);
        chk(noise_err == 1'b1, "R8", "error set", noise_err, 1);
        chk(obs_pulses == 0, "R8", "no count on illegal step", obs_pulses, 0);
        window(); move(1, 2); hold(4);
        chk(noise_err == 1'b1, "R8", "error sticky", noise_err, 1);
        chk(obs_pulses == 2, "R8", "counting continues", obs_pulses, 2);

        // clear, then clear coinciding with a new error
        cur_req = "R9";
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
        hold(2);
        chk(noise_err == 1'b0, "R9", "error cleared", noise_err, 0);
        @(negedge clk); line_a = 1'b1; line_b = 1'b1;
        @(negedge clk);
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
        hold(2);
        chk(noise_err == 1'b1, "R9", "set wins over clear", noise_err, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule